// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master Sequencer

This block is the master side of a DMA engine on a 16-bit bus that carries both address and data. Internal logic issues a request with a direction, a word address, a write word and a transfer count. The block then runs one transfer or a burst of transfers on the shared lines. Each transfer first puts the address on the lines and then moves the data word. A strobe marks the data phase, and data is valid at the strobe's rising edge.

Alongside the shared lines, the block drives a direction line and two enables for an external bidirectional transceiver, one for each direction. Each enable follows the phase and the direction of the transfer. The direction line, the strobe and both enables are released whenever no transfer is running. A host may end a burst early through a release input. That input counts only when a configuration bit allows it, and it always ends the burst at a transfer boundary.

Top module: `muxbus_master`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `ctl_oe`, `ad_oe`, `txo_out` and `txi_out` are all low.
- R2: The cycle after a request is accepted is the address cycle. In it `ad_out` carries the request address, `ad_oe`, `txo_out` and `strobe_out` are high, `txi_out` is low, and `dir_out` is 1 for a read and 0 for a write.
- R3: The address cycle is followed by exactly one cycle with `strobe_out` low. In the next cycle `strobe_out` is high again, which is the rising edge that defines valid data.
- R4: For a write, `ad_oe` and `txo_out` stay high in all three cycles of the transfer, `txi_out` stays low, and `ad_out` carries the write word during the strobe-low and recovery cycles.
- R5: For a read, `ad_oe` and `txo_out` are high only in the address cycle. `txi_out` is high in the strobe-low cycle and the recovery cycle, and low at every other time.
- R6: `done` is high for exactly one cycle, the recovery cycle after the strobe rises. For a read, `rdata` then holds the value of `ad_in` from the strobe-low cycle.
- R7: `ctl_oe` (the enable for direction, strobe and both transceiver enables) and `ad_oe` are low whenever `busy` is low.
- R8: A burst runs `req_count` transfers, and a count of 0 runs one transfer. Each transfer's address is 2 above the previous one, modulo 2^16. Transfers follow each other with no idle cycle between them.
- R9: With `rel_en` = 1, a high `host_rel` in any cycle of a transfer lets that transfer finish and then returns the block to idle.
- R10: With `rel_en` = 0, `host_rel` has no effect and the burst runs its full count.
- R11: `req_valid` is ignored while `busy` is high. The running burst keeps its addresses and length.
- R12: The write word is sampled from `req_wdata` on the clock edge that enters each address cycle, so every word of a burst can be different.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request start (accepted when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Starting word address (low 16 bits) |
| req_wdata | input | 16 | Write word, sampled at each address-cycle entry |
| req_count | input | 4 | Transfers in the burst (0 counts as 1) |
| rel_en | input | 1 | Configuration bit enabling the host release |
| host_rel | input | 1 | Host request to end the burst |
| busy | output | 1 | Block is bus master |
| done | output | 1 | One-cycle pulse per completed transfer |
| rdata | output | 16 | Captured read word, valid with `done` |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared address/data lines, received value |
| dir_out | output | 1 | Direction: 1 read, 0 write |
| strobe_out | output | 1 | Data strobe, low during the data cycle |
| txo_out | output | 1 | Transceiver outbound enable |
| txi_out | output | 1 | Transceiver inbound enable |
| ctl_oe | output | 1 | Drive enable for direction, strobe and transceiver enables |

## Verification
The bench uses the default widths: 16-bit lines and a 4-bit count, so bursts of up to 15 words. With these values a single read using a count of 0, a read burst that wraps past address 0xFFFE, a five-word burst that ignores a new request, and releases with the enable bit both set and clear all fit in a short run. The bench acts as a slave that returns the address XOR 0x5A3C, so every captured read word can be predicted.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_REC  = 2'd3
  } phase_t;
endpackage

// File: rtl/muxbus_phase_fsm.sv
module muxbus_phase_fsm
  import muxbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   last_xfer,
  input  logic   rel_stop,
  output phase_t phase,
  output logic   accept,
  output logic   advance
);
  phase_t phase_q, phase_d;

  assign accept  = (phase_q == PH_IDLE) && req_valid;
  assign advance = (phase_q == PH_REC) && !last_xfer && !rel_stop;
  assign phase   = phase_q;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (req_valid) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_DATA;
      PH_DATA: phase_d = PH_REC;
      PH_REC:  phase_d = advance ? PH_ADDR : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end
endmodule

// File: rtl/muxbus_addr_gen.sv
module muxbus_addr_gen #(
  parameter int DW    = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             advance,
  input  logic [DW-1:0]    start_addr,
  input  logic [LEN_W-1:0] count,
  output logic [DW-1:0]    addr,
  output logic             last_xfer
);
  localparam int STEP = DW / 8;
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  logic [DW-1:0]    addr_q;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (accept) begin
      addr_q <= start_addr;
      left_q <= (count == '0) ? '0 : count - 1'b1;
    end else if (advance) begin
      addr_q <= addr_q + STEP_V;
      left_q <= left_q - 1'b1;
    end
  end

  assign addr      = addr_q;
  assign last_xfer = (left_q == '0);
endmodule

// File: rtl/muxbus_release.sv
module muxbus_release
  import muxbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase,
  input  logic   accept,
  input  logic   rel_en,
  input  logic   host_rel,
  output logic   rel_stop
);
  logic seen_q;
  logic hit;

  assign hit = rel_en && host_rel && (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst || accept) seen_q <= 1'b0;
    else if (hit)      seen_q <= 1'b1;
  end

  assign rel_stop = rel_en && (seen_q || host_rel);
endmodule

// File: rtl/muxbus_pins.sv
module muxbus_pins
  import muxbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  phase_t        phase,
  input  logic          is_read,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] wword,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          dir_out,
  output logic          strobe_out,
  output logic          txo_out,
  output logic          txi_out,
  output logic          ctl_oe,
  output logic          done,
  output logic          busy
);
  logic master;
  logic data_side;

  assign master    = (phase != PH_IDLE);
  assign data_side = (phase == PH_DATA) || (phase == PH_REC);

  always_comb begin
    ad_out     = '0;
    ad_oe      = 1'b0;
    txo_out    = 1'b0;
    txi_out    = 1'b0;
    strobe_out = 1'b1;
    if (phase == PH_ADDR) begin
      ad_out  = addr;
      ad_oe   = 1'b1;
      txo_out = 1'b1;
    end else if (data_side) begin
      if (is_read) begin
        txi_out = 1'b1;
      end else begin
        ad_out  = wword;
        ad_oe   = 1'b1;
        txo_out = 1'b1;
      end
    end
    if (phase == PH_DATA) strobe_out = 1'b0;
  end

  assign dir_out = master && is_read;
  assign ctl_oe  = master;
  assign busy    = master;
  assign done    = (phase == PH_REC);
endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
  import muxbus_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [DW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LEN_W-1:0] req_count,
  input  logic             rel_en,
  input  logic             host_rel,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic             dir_out,
  output logic             strobe_out,
  output logic             txo_out,
  output logic             txi_out,
  output logic             ctl_oe
);
  phase_t        phase;
  logic          accept, advance, last_xfer, rel_stop;
  logic [DW-1:0] addr;
  logic          is_read_q;
  logic [DW-1:0] wword_q;
  logic [DW-1:0] rdata_q;

  muxbus_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .last_xfer(last_xfer),
    .rel_stop(rel_stop), .phase(phase), .accept(accept), .advance(advance)
  );

  muxbus_addr_gen #(.DW(DW), .LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst(rst), .accept(accept), .advance(advance),
    .start_addr(req_addr), .count(req_count), .addr(addr), .last_xfer(last_xfer)
  );

  muxbus_release u_rel (
    .clk(clk), .rst(rst), .phase(phase), .accept(accept),
    .rel_en(rel_en), .host_rel(host_rel), .rel_stop(rel_stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      is_read_q <= 1'b0;
      wword_q   <= '0;
      rdata_q   <= '0;
    end else begin
      if (accept) is_read_q <= !req_write;
      if (accept || advance) wword_q <= req_wdata;
      if (phase == PH_DATA && is_read_q) rdata_q <= ad_in;
    end
  end

  muxbus_pins #(.DW(DW)) u_pins (
    .phase(phase), .is_read(is_read_q), .addr(addr), .wword(wword_q),
    .ad_out(ad_out), .ad_oe(ad_oe), .dir_out(dir_out), .strobe_out(strobe_out),
    .txo_out(txo_out), .txi_out(txi_out), .ctl_oe(ctl_oe), .done(done), .busy(busy)
  );

  assign rdata = rdata_q;
endmodule

// File: rtl/muxbus_master_chk.sv
module muxbus_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic ad_oe,
  input logic dir_out,
  input logic strobe_out,
  input logic txo_out,
  input logic txi_out,
  input logic ctl_oe
);
  // R2
  addr_cycle_drive_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_oe) |-> (ad_oe && txo_out && strobe_out && !txi_out));
  // R3
  strobe_low_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_oe && !strobe_out) |=> (ctl_oe && strobe_out));
  // R4
  write_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_oe && !dir_out) |-> (ad_oe && txo_out && !txi_out));
  // R5
  read_inbound_chk: assert property (@(posedge clk) disable iff (rst)
    txi_out |-> (dir_out && !ad_oe && !txo_out));
  // R6
  done_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (strobe_out && $past(ctl_oe) && !$past(strobe_out)));
  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_oe |-> (!ad_oe && !txo_out && !txi_out && !done));
endmodule

bind muxbus_master muxbus_master_chk i_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .ad_oe(ad_oe),
  .dir_out(dir_out), .strobe_out(strobe_out), .txo_out(txo_out),
  .txi_out(txi_out), .ctl_oe(ctl_oe)
);

// File: tb/test_muxbus_master.sv
`timescale 1ns/1ps
module test_muxbus_master;
  localparam int DW = 16;
  localparam int LEN_W = 4;
  localparam logic [15:0] PAT = 16'h5A3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [DW-1:0] req_addr = '0, req_wdata = '0;
  logic [LEN_W-1:0] req_count = '0;
  logic rel_en = 1'b0, host_rel = 1'b0;
  logic busy, done, ad_oe, dir_out, strobe_out, txo_out, txi_out, ctl_oe;
  logic [DW-1:0] rdata, ad_out;
  logic [DW-1:0] slave_data = '0;

  always #2.5 clk = ~clk;

  muxbus_master #(.DW(DW), .LEN_W(LEN_W)) i_muxbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_count(req_count),
    .rel_en(rel_en), .host_rel(host_rel), .busy(busy), .done(done),
    .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(slave_data),
    .dir_out(dir_out), .strobe_out(strobe_out), .txo_out(txo_out),
    .txi_out(txi_out), .ctl_oe(ctl_oe)
  );

  typedef struct packed { logic w; logic [15:0] a; logic [15:0] d; } item_t;
  item_t exp_q[$];
  item_t cur;
  int checks = 0, fails = 0;
  int mph = 0;
  int cyc = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  // monitor: pops one expected item per address cycle
  always @(negedge clk) begin
    if (!rst) begin
      case (mph)
        0: if (ctl_oe) begin
             if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected transfer", {16'h0, ad_out}, 32'h0);
               cur = '0;
             end else cur = exp_q.pop_front();
             chk(ad_oe && ad_out == cur.a, "R2 address", {16'h0, ad_out}, {16'h0, cur.a});
             chk(dir_out == !cur.w && strobe_out && txo_out && !txi_out && !done,
                 "R2 controls", {27'h0, dir_out, strobe_out, txo_out, txi_out, done},
                 {27'h0, !cur.w, 1'b1, 1'b1, 1'b0, 1'b0});
             slave_data = cur.a ^ PAT;
             mph = 1;
           end else begin
             if (ad_oe || txo_out || txi_out || busy)
               chk(1'b0, "R7 idle release", {28'h0, ad_oe, txo_out, txi_out, busy}, 32'h0);
           end
        1: begin
             chk(ctl_oe && !strobe_out && !done, "R3 strobe low", {30'h0, strobe_out, done}, 32'h0);
             if (cur.w)
               chk(ad_oe && txo_out && !txi_out && ad_out == cur.d, "R4 write data",
                   {13'h0, ad_oe, txo_out, txi_out, ad_out}, {13'h0, 3'b110, cur.d});
             else
               chk(!ad_oe && !txo_out && txi_out, "R5 read enables",
                   {29'h0, ad_oe, txo_out, txi_out}, 32'h1);
             mph = 2;
           end
        default: begin
             chk(ctl_oe && strobe_out && done, "R6 done after rise",
                 {29'h0, ctl_oe, strobe_out, done}, 32'h7);
             if (cur.w)
               chk(ad_oe && txo_out && !txi_out && ad_out == cur.d, "R4 write hold",
                   {13'h0, ad_oe, txo_out, txi_out, ad_out}, {13'h0, 3'b110, cur.d});
             else begin
               chk(!ad_oe && !txo_out && txi_out, "R5 read hold",
                   {29'h0, ad_oe, txo_out, txi_out}, 32'h1);
               chk(rdata == cur.d, "R6 read data", {16'h0, rdata}, {16'h0, cur.d});
             end
             mph = 0;
           end
      endcase
    end
  end

  task automatic run(input logic w, input logic [15:0] a, input int n, input int nexp,
                     input int rel_at, input logic ren, input logic [15:0] wbase,
                     input logic junk, input string tag);
    int k = 0;
    for (int i = 0; i < nexp; i++) begin
      logic [15:0] ai;
      ai = a + 16'(2 * i);
      exp_q.push_back({w, ai, w ? wbase + 16'(i) : (ai ^ PAT)});
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_count = LEN_W'(n);
    req_wdata = wbase; rel_en = ren;
    @(negedge clk);
    req_valid = junk;
    if (junk) begin req_addr = 16'hFFF0; req_count = 4'd1; req_write = !w; end
    while (busy) begin
      host_rel = 1'b0;
      if (done) begin
        if (k == rel_at) host_rel = 1'b1;
        k++;
        req_wdata = wbase + 16'(k);
      end
      @(negedge clk);
    end
    host_rel = 1'b0;
    req_valid = 1'b0;
    chk(k == nexp && exp_q.size() == 0, tag, 32'(k), 32'(nexp));
    @(negedge clk);
    chk(!busy && !ctl_oe, tag, {31'h0, busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !ctl_oe && !ad_oe && !txo_out && !txi_out, "R1 reset state",
        {26'h0, busy, done, ctl_oe, ad_oe, txo_out, txi_out}, 32'h0);
    run(1'b1, 16'h1234, 1, 1, -1, 1'b0, 16'hBEEF, 1'b0, "R4 single write");
    run(1'b0, 16'h0100, 0, 1, -1, 1'b0, 16'h0000, 1'b0, "R8 zero count read");
    run(1'b1, 16'h2000, 4, 4, -1, 1'b0, 16'hA000, 1'b0, "R12 write burst words");
    run(1'b0, 16'hFFFC, 3, 3, -1, 1'b0, 16'h0000, 1'b0, "R8 read burst wrap");
    run(1'b1, 16'h3000, 6, 2, 1, 1'b1, 16'hC100, 1'b0, "R9 release ends burst");
    run(1'b0, 16'h4000, 3, 3, 0, 1'b0, 16'h0000, 1'b0, "R10 release ignored");
    run(1'b0, 16'h5000, 5, 5, -1, 1'b0, 16'h0000, 1'b1, "R11 request while busy");
    run(1'b0, 16'h6000, 2, 1, 0, 1'b1, 16'h0000, 1'b0, "R9 release on first");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule